// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a compact processor that completes one instruction in every clock cycle. On each rising edge it commits the effects of the word presented on its instruction port: a register write, a data-memory store, and the new program counter. The address of the next instruction comes straight from the program-counter register. Operands come from a 32-entry by 32-bit register file with combinational reads. An ALU does add, subtract, signed compare, AND, OR and upper-half placement. Loads and stores use a byte-addressed, word-wide data port.

Instructions come in three layouts. The opcode is always in bits [31:26]. The register form carries rs [25:21], rt [20:16], rd [15:11] and a function code in [5:0]. The immediate form carries rs, rt and a 16-bit constant in [15:0]. The jump form carries a 26-bit word target in [25:0].

The decoder first sorts each word into an instruction class: idle, register arithmetic, register jump, immediate arithmetic, load, store, branch or jump. A second process turns the class into datapath controls. The next-PC selector then chooses one of five sources: sequential, branch on equal, branch on not equal, region jump, or register jump. Both memories sit outside the block. Their reads are combinational and the data-memory write happens at the clock edge.

Top module: `scr_core`

## Requirements
- R1: While rst_n is low, every rising edge forces the program counter to 0 and dmem_we stays low. After release, the first fetch comes from address 0.
- R2: Opcode 0 with function 32 writes rs+rt to rd, and function 34 writes rs-rt to rd. Both results wrap modulo 2^32 and raise no trap.
- R3: Opcode 0 with function 42, and opcode 10, write 1 to the destination when rs is below the second operand as signed two's complement, and write 0 otherwise. The second operand is rt for function 42 and the sign-extended immediate for opcode 10.
- R4: Opcode 8 writes rs plus the sign-extended immediate to rt. Opcodes 12 and 13 write rs AND, and rs OR, the zero-extended immediate to rt.
- R5: Opcode 15 writes the immediate into rt[31:16] and clears rt[15:0]. An opcode 13 that follows can then fill in the lower half.
- R6: Opcode 35 reads the word at address rs plus the sign-extended immediate and writes it to rt.
- R7: Opcode 43 raises dmem_we with address rs plus the sign-extended immediate and write data rt, and writes no register.
- R8: Register 0 always reads 0 and ignores writes. Any other register returns a written value from the following cycle on.
- R9: Opcode 4 (taken when rs equals rt) and opcode 5 (taken when they differ) set the next PC to PC+4 plus the sign-extended immediate shifted left by 2 when taken. When not taken, the next PC is PC+4.
- R10: Opcode 2 sets the next PC to {(PC+4)[31:28], target, 2'b00}, so the top four PC bits do not change.
- R11: Opcode 0 with function 8 sets the next PC to the value of register rs.
- R12: Any other opcode, and opcode 0 with any other function, writes no register and no memory and moves the PC to PC+4.
- R13: Every instruction not listed under R9 to R11 moves the PC to PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_data | input | 32 | Instruction word at imem_addr, combinational |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, written at the next rising edge |
| dmem_rdata | input | 32 | Load data at dmem_addr, combinational |

## Verification
The bench goes after signed-versus-unsigned confusion in set-less-than, using operands that straddle the sign bit. A core that compares unsigned would report 0x80000000 as larger than 1. It also uses immediates with bit 15 set. These catch a mix-up between sign and zero extension: addi would then add a large positive value, or andi and ori would smear ones into the upper half. Negative load and store offsets expose a missing sign extension in address generation, which would put the access 64 KiB too high. Branch tests cover taken and not-taken cases of both senses, plus a backward loop. A core with the senses swapped, or without the shift by 2, lands on the wrong word and leaves the wrong marker values in memory. The last tests run a jump from a PC in an upper region to check that the top PC bits survive (a core that dropped them would fall back into region 0). They also check that writes to register 0 and unknown opcodes leave register and memory state untouched.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RAW  = $clog2(NREG);
    localparam int IMMW = 16;
    localparam int TGTW = 26;
    localparam int OPW  = 6;
    localparam int FNW  = 6;

    localparam logic [OPW-1:0] OP_REG  = 6'd0;
    localparam logic [OPW-1:0] OP_J    = 6'd2;
    localparam logic [OPW-1:0] OP_BEQ  = 6'd4;
    localparam logic [OPW-1:0] OP_BNE  = 6'd5;
    localparam logic [OPW-1:0] OP_ADDI = 6'd8;
    localparam logic [OPW-1:0] OP_SLTI = 6'd10;
    localparam logic [OPW-1:0] OP_ANDI = 6'd12;
    localparam logic [OPW-1:0] OP_ORI  = 6'd13;
    localparam logic [OPW-1:0] OP_LUI  = 6'd15;
    localparam logic [OPW-1:0] OP_LW   = 6'd35;
    localparam logic [OPW-1:0] OP_SW   = 6'd43;

    localparam logic [FNW-1:0] FN_JR  = 6'd8;
    localparam logic [FNW-1:0] FN_ADD = 6'd32;
    localparam logic [FNW-1:0] FN_SUB = 6'd34;
    localparam logic [FNW-1:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_SLT,
        ALU_AND,
        ALU_OR,
        ALU_UPPER
    } alu_op_e;

    typedef enum logic [2:0] {
        PC_SEQ,
        PC_BR_EQ,
        PC_BR_NE,
        PC_JUMP,
        PC_JREG
    } pc_sel_e;

    typedef enum logic [2:0] {
        CL_IDLE,
        CL_REG,
        CL_JREG,
        CL_IMM,
        CL_LOAD,
        CL_STORE,
        CL_BRANCH,
        CL_JUMP
    } ins_class_e;

    typedef struct packed {
        alu_op_e alu_op;
        logic    b_is_imm;
        logic    imm_zero;
        logic    wr_en;
        logic    wr_sel_rd;
        logic    mem_rd;
        logic    mem_wr;
        pc_sel_e pc_sel;
    } ctrl_t;

endpackage

// File: rtl/scr_decoder.sv
module scr_decoder
    import scr_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  logic [FNW-1:0] funct,
    output ins_class_e     cls,
    output ctrl_t          ctrl
);

    alu_op_e alu_sel;

    // Classification process: opcode and function code pick the class.
    always_comb begin
        cls     = CL_IDLE;
        alu_sel = ALU_ADD;
        unique case (op)
            OP_REG: begin
                unique case (funct)
                    FN_ADD:  begin cls = CL_REG;  alu_sel = ALU_ADD; end
                    FN_SUB:  begin cls = CL_REG;  alu_sel = ALU_SUB; end
                    FN_SLT:  begin cls = CL_REG;  alu_sel = ALU_SLT; end
                    FN_JR:   begin cls = CL_JREG; alu_sel = ALU_ADD; end
                    default: begin cls = CL_IDLE; alu_sel = ALU_ADD; end
                endcase
            end
            OP_ADDI: begin cls = CL_IMM;    alu_sel = ALU_ADD;   end
            OP_SLTI: begin cls = CL_IMM;    alu_sel = ALU_SLT;   end
            OP_ANDI: begin cls = CL_IMM;    alu_sel = ALU_AND;   end
            OP_ORI:  begin cls = CL_IMM;    alu_sel = ALU_OR;    end
            OP_LUI:  begin cls = CL_IMM;    alu_sel = ALU_UPPER; end
            OP_LW:   begin cls = CL_LOAD;   alu_sel = ALU_ADD;   end
            OP_SW:   begin cls = CL_STORE;  alu_sel = ALU_ADD;   end
            OP_BEQ:  begin cls = CL_BRANCH; alu_sel = ALU_SUB;   end
            OP_BNE:  begin cls = CL_BRANCH; alu_sel = ALU_SUB;   end
            OP_J:    begin cls = CL_JUMP;   alu_sel = ALU_ADD;   end
            default: begin cls = CL_IDLE;   alu_sel = ALU_ADD;   end
        endcase
    end

    // Control process: class drives the datapath steering.
    always_comb begin
        ctrl           = '0;
        ctrl.alu_op    = alu_sel;
        ctrl.pc_sel    = PC_SEQ;
        ctrl.imm_zero  = (op == OP_ANDI) || (op == OP_ORI) || (op == OP_LUI);
        unique case (cls)
            CL_IDLE: begin
                ctrl.wr_en = 1'b0;
            end
            CL_REG: begin
                ctrl.wr_en     = 1'b1;
                ctrl.wr_sel_rd = 1'b1;
            end
            CL_JREG: begin
                ctrl.pc_sel = PC_JREG;
            end
            CL_IMM: begin
                ctrl.wr_en    = 1'b1;
                ctrl.b_is_imm = 1'b1;
            end
            CL_LOAD: begin
                ctrl.wr_en    = 1'b1;
                ctrl.b_is_imm = 1'b1;
                ctrl.mem_rd   = 1'b1;
            end
            CL_STORE: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.mem_wr   = 1'b1;
            end
            CL_BRANCH: begin
                ctrl.pc_sel = (op == OP_BEQ) ? PC_BR_EQ : PC_BR_NE;
            end
            CL_JUMP: begin
                ctrl.pc_sel = PC_JUMP;
            end
            default: begin
                ctrl.wr_en = 1'b0;
            end
        endcase
    end

    // R7: a store class never also claims a register write
    always_comb begin
        a_r7_store_no_regwrite: assert (!(ctrl.mem_wr && ctrl.wr_en));
    end

endmodule

// File: rtl/scr_regfile.sv
module scr_regfile #(
    parameter int W    = 32,
    parameter int N    = 32,
    localparam int AW  = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] regs_q [N];

    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) begin
            regs_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata_a = (raddr_a == '0) ? '0 : regs_q[raddr_a];
        rdata_b = (raddr_b == '0) ? '0 : regs_q[raddr_b];
    end

    // R8: a value written to a nonzero register is returned on the next cycle
    a_r8_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (waddr != '0)) ##1 (raddr_a == $past(waddr)) |-> (rdata_a == $past(wdata)));

    // R8: register zero reads zero even right after a write aimed at it
    a_r8_zero_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (waddr == '0)) ##1 (raddr_b == '0) |-> (rdata_b == '0));

endmodule

// File: rtl/scr_alu.sv
module scr_alu
    import scr_pkg::*;
#(
    parameter int W    = 32,
    localparam int HALF = W / 2
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    always_comb begin
        unique case (op)
            ALU_ADD:   y = a + b;
            ALU_SUB:   y = a - b;
            ALU_SLT:   y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_AND:   y = a & b;
            ALU_OR:    y = a | b;
            ALU_UPPER: y = {b[HALF-1:0], {HALF{1'b0}}};
            default:   y = a + b;
        endcase
    end

endmodule

// File: rtl/scr_next_pc.sv
module scr_next_pc
    import scr_pkg::*;
#(
    parameter int W   = 32,
    parameter int TW  = 26,
    localparam int KEEP = W - TW - 2
) (
    input  pc_sel_e       sel,
    input  logic [W-1:0]  pc,
    input  logic [W-1:0]  offset_ext,
    input  logic [TW-1:0] target,
    input  logic [W-1:0]  reg_target,
    input  logic          same,
    output logic [W-1:0]  next_pc
);

    logic [W-1:0] pc_inc;
    logic [W-1:0] br_dest;
    logic [W-1:0] jmp_dest;

    always_comb begin
        pc_inc   = pc + W'(4);
        br_dest  = pc_inc + (offset_ext << 2);
        jmp_dest = {pc_inc[W-1 -: KEEP], target, 2'b00};
        unique case (sel)
            PC_SEQ:   next_pc = pc_inc;
            PC_BR_EQ: next_pc = same ? br_dest : pc_inc;
            PC_BR_NE: next_pc = same ? pc_inc : br_dest;
            PC_JUMP:  next_pc = jmp_dest;
            PC_JREG:  next_pc = reg_target;
            default:  next_pc = pc_inc;
        endcase
    end

endmodule

// File: rtl/scr_core.sv
module scr_core
    import scr_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_data,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_d;
    ins_class_e      cls;
    ctrl_t           ctrl;

    logic [OPW-1:0]  f_op;
    logic [RAW-1:0]  f_rs;
    logic [RAW-1:0]  f_rt;
    logic [RAW-1:0]  f_rd;
    logic [FNW-1:0]  f_fn;
    logic [IMMW-1:0] f_imm;
    logic [TGTW-1:0] f_tgt;

    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] imm_sext;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] wb_data;
    logic [RAW-1:0]  wb_addr;
    logic            wb_en;

    // Instruction fields
    always_comb begin
        f_op  = imem_data[31:26];
        f_rs  = imem_data[25:21];
        f_rt  = imem_data[20:16];
        f_rd  = imem_data[15:11];
        f_fn  = imem_data[5:0];
        f_imm = imem_data[15:0];
        f_tgt = imem_data[25:0];
    end

    scr_decoder u_dec (
        .op    (f_op),
        .funct (f_fn),
        .cls   (cls),
        .ctrl  (ctrl)
    );

    scr_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wb_en),
        .waddr   (wb_addr),
        .wdata   (wb_data),
        .raddr_a (f_rs),
        .raddr_b (f_rt),
        .rdata_a (rs_val),
        .rdata_b (rt_val)
    );

    always_comb begin
        imm_sext = {{(XLEN-IMMW){f_imm[IMMW-1]}}, f_imm};
        imm_ext  = ctrl.imm_zero ? {{(XLEN-IMMW){1'b0}}, f_imm} : imm_sext;
        alu_b    = ctrl.b_is_imm ? imm_ext : rt_val;
    end

    scr_alu #(.W(XLEN)) u_alu (
        .op (ctrl.alu_op),
        .a  (rs_val),
        .b  (alu_b),
        .y  (alu_y)
    );

    scr_next_pc #(.W(XLEN), .TW(TGTW)) u_npc (
        .sel        (ctrl.pc_sel),
        .pc         (pc_q),
        .offset_ext (imm_sext),
        .target     (f_tgt),
        .reg_target (rs_val),
        .same       (rs_val == rt_val),
        .next_pc    (pc_d)
    );

    // Program counter register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else begin
            pc_q <= pc_d;
        end
    end

    // Write-back and memory-side outputs
    always_comb begin
        wb_en      = ctrl.wr_en && rst_n;
        wb_addr    = ctrl.wr_sel_rd ? f_rd : f_rt;
        wb_data    = ctrl.mem_rd ? dmem_rdata : alu_y;
        imem_addr  = pc_q;
        dmem_addr  = alu_y;
        dmem_wdata = rt_val;
        dmem_we    = ctrl.mem_wr && rst_n;
    end

    // R13: sequential instructions step by one word
    a_r13_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.pc_sel == PC_SEQ) |=> (imem_addr == $past(imem_addr) + 32'd4));

    // R9: a taken equal-branch lands on the offset word
    a_r9_beq_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.pc_sel == PC_BR_EQ && rs_val == rt_val)
        |=> (imem_addr == $past(imem_addr + 32'd4 + (imm_sext << 2))));

    // R10: a region jump keeps the upper four bits of PC+4
    a_r10_region_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.pc_sel == PC_JUMP)
        |=> (imem_addr[31:28] == $past(imem_addr + 32'd4) >> 28) && (imem_addr[1:0] == 2'b00));

    // R11: a register jump loads the PC from rs
    a_r11_reg_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.pc_sel == PC_JREG) |=> (imem_addr == $past(rs_val)));

    // R12: an unrecognised word neither stores nor writes a register
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CL_IDLE) |-> (!dmem_we && !wb_en));

endmodule

// File: tb/tb_scr_core.sv
module tb_scr_core;

    logic        clk;
    logic        rst_n;
    logic [31:0] imem_addr;
    logic [31:0] imem_data;
    logic [31:0] dmem_addr;
    logic [31:0] dmem_wdata;
    logic        dmem_we;
    logic [31:0] dmem_rdata;

    logic [31:0] imem [0:255];
    logic [31:0] dmem [0:255];

    int checks = 0;
    int errors = 0;
    int wp     = 0;
    bit done   = 0;

    localparam logic [31:0] NOPW = 32'hFC00_0000;
    localparam logic [31:0] SENT = 32'hDEAD_BEEF;

    scr_core dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    assign imem_data  = imem[imem_addr[9:2]];
    assign dmem_rdata = dmem[dmem_addr[9:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;
    end

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [4:0] rd);
        return {6'd0, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(input logic [25:0] tgt);
        return {6'd2, tgt};
    endfunction

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] lt_s(input logic [31:0] a, input logic [31:0] b);
        return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic emit(input logic [31:0] w);
        imem[wp] = w;
        wp++;
    endtask

    task automatic hold_and_clear();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 256; i++) begin
            imem[i] = NOPW;
            dmem[i] = SENT;
        end
        wp = 0;
    endtask

    task automatic release_and_run(input bit look_reset, input int cycles);
        @(posedge clk);
        @(negedge clk);
        if (look_reset) begin
            chk("R1 pc held at zero", imem_addr, 32'd0);
            chk("R1 no store in reset", {31'd0, dmem_we}, 32'd0);
        end
        rst_n = 1'b1;
        if (look_reset) chk("R1 first fetch", imem_addr, 32'd0);
        @(negedge clk);
        if (look_reset) chk("R13 step by four", imem_addr, 32'd4);
        repeat (cycles - 1) @(negedge clk);
    endtask

    task automatic alu_case(input logic [31:0] a, input logic [31:0] b,
                            input logic [15:0] imm, input bit first);
        int halt;
        hold_and_clear();
        emit(enc_i(6'd15, 5'd0, 5'd1, a[31:16]));
        emit(enc_i(6'd13, 5'd1, 5'd1, a[15:0]));
        emit(enc_i(6'd15, 5'd0, 5'd2, b[31:16]));
        emit(enc_i(6'd13, 5'd2, 5'd2, b[15:0]));
        emit(enc_r(6'd32, 5'd1, 5'd2, 5'd3));
        emit(enc_r(6'd34, 5'd1, 5'd2, 5'd4));
        emit(enc_r(6'd42, 5'd1, 5'd2, 5'd5));
        emit(enc_i(6'd8,  5'd1, 5'd6, imm));
        emit(enc_i(6'd10, 5'd1, 5'd7, imm));
        emit(enc_i(6'd12, 5'd1, 5'd8, imm));
        emit(enc_i(6'd13, 5'd1, 5'd9, imm));
        emit(enc_i(6'd15, 5'd0, 5'd10, imm));
        emit(enc_i(6'd8,  5'd1, 5'd0, imm));
        emit(enc_i(6'd63, 5'd1, 5'd3, imm));
        emit(enc_r(6'd17, 5'd1, 5'd2, 5'd4));
        emit(enc_i(6'd8,  5'd0, 5'd12, 16'd256));
        emit(enc_i(6'd43, 5'd0, 5'd3,  16'd0));
        emit(enc_i(6'd43, 5'd0, 5'd4,  16'd4));
        emit(enc_i(6'd43, 5'd0, 5'd5,  16'd8));
        emit(enc_i(6'd43, 5'd0, 5'd6,  16'd12));
        emit(enc_i(6'd43, 5'd0, 5'd7,  16'd16));
        emit(enc_i(6'd43, 5'd0, 5'd8,  16'd20));
        emit(enc_i(6'd43, 5'd0, 5'd9,  16'd24));
        emit(enc_i(6'd43, 5'd0, 5'd10, 16'd28));
        emit(enc_i(6'd43, 5'd0, 5'd0,  16'd32));
        emit(enc_i(6'd35, 5'd12, 5'd13, 16'hFF04));
        emit(enc_i(6'd43, 5'd12, 5'd13, 16'hFF24));
        halt = wp;
        emit(enc_j(26'(halt)));
        release_and_run(first, 40);
        chk("R2 add wraps", dmem[0], a + b);
        chk("R2 sub wraps", dmem[1], a - b);
        chk("R3 slt signed", dmem[2], lt_s(a, b));
        chk("R4 addi sign-extends", dmem[3], a + sx(imm));
        chk("R3 slti signed", dmem[4], lt_s(a, sx(imm)));
        chk("R4 andi zero-extends", dmem[5], a & {16'd0, imm});
        chk("R4 ori zero-extends", dmem[6], a | {16'd0, imm});
        chk("R5 lui upper half", dmem[7], {imm, 16'd0});
        chk("R8 reg zero reads zero", dmem[8], 32'd0);
        chk("R6 R7 load and store negative offset", dmem[9], a - b);
        chk("R12 unknown word stores nothing", dmem[10], SENT);
        chk("R10 halt holds pc", imem_addr, 32'(halt * 4));
    endtask

    task automatic flow_case();
        int b0;
        hold_and_clear();
        for (int r = 21; r <= 29; r++) emit(enc_i(6'd8, 5'd0, 5'(r), 16'd0));
        b0 = wp;
        emit(enc_i(6'd8, 5'd0, 5'd1, 16'd5));
        emit(enc_i(6'd8, 5'd0, 5'd2, 16'd5));
        emit(enc_i(6'd8, 5'd0, 5'd3, 16'd7));
        emit(enc_i(6'd4, 5'd1, 5'd2, 16'd1));
        emit(enc_i(6'd8, 5'd0, 5'd21, 16'd1));
        emit(enc_i(6'd5, 5'd1, 5'd2, 16'd1));
        emit(enc_i(6'd8, 5'd0, 5'd22, 16'd1));
        emit(enc_i(6'd5, 5'd1, 5'd3, 16'd1));
        emit(enc_i(6'd8, 5'd0, 5'd23, 16'd1));
        emit(enc_i(6'd4, 5'd1, 5'd3, 16'd1));
        emit(enc_i(6'd8, 5'd0, 5'd24, 16'd1));
        emit(enc_j(26'(b0 + 13)));
        emit(enc_i(6'd8, 5'd0, 5'd25, 16'd1));
        emit(enc_i(6'd8, 5'd0, 5'd30, 16'(4 * (b0 + 17))));
        emit(enc_r(6'd8, 5'd30, 5'd0, 5'd0));
        emit(enc_i(6'd8, 5'd0, 5'd26, 16'd1));
        emit(enc_i(6'd8, 5'd0, 5'd27, 16'd1));
        emit(enc_i(6'd8, 5'd29, 5'd29, 16'd1));
        emit(enc_i(6'd5, 5'd29, 5'd3, 16'hFFFE));
        for (int r = 21; r <= 27; r++) emit(enc_i(6'd43, 5'd0, 5'(r), 16'(4 * (r - 21))));
        emit(enc_i(6'd43, 5'd0, 5'd29, 16'd28));
        emit(enc_i(6'd15, 5'd0, 5'd28, 16'h1000));
        emit(enc_i(6'd13, 5'd28, 5'd28, 16'(4 * (b0 + 32))));
        emit(enc_r(6'd8, 5'd28, 5'd0, 5'd0));
        emit(enc_i(6'd43, 5'd0, 5'd3, 16'd32));
        emit(NOPW);
        emit(enc_j(26'(b0 + 34)));
        emit(enc_i(6'd43, 5'd0, 5'd3, 16'd32));
        emit(enc_j(26'(b0 + 34)));
        release_and_run(0, 120);
        chk("R9 beq taken skips", dmem[0], 32'd0);
        chk("R9 bne not taken falls through", dmem[1], 32'd1);
        chk("R9 bne taken skips", dmem[2], 32'd0);
        chk("R9 beq not taken falls through", dmem[3], 32'd1);
        chk("R10 jump skips", dmem[4], 32'd0);
        chk("R11 jr skips first", dmem[5], 32'd0);
        chk("R11 jr skips second", dmem[6], 32'd0);
        chk("R9 backward loop count", dmem[7], 32'd7);
        chk("R11 jr into upper region skips store", dmem[8], SENT);
        chk("R10 jump keeps upper pc bits", imem_addr, 32'h1000_0000 + 32'(4 * (b0 + 34)));
    endtask

    initial begin
        logic [31:0] ra;
        logic [31:0] rb;
        logic [15:0] ri;
        rst_n = 1'b0;
        ra = $urandom(32'd7331);
        alu_case(32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h8000, 1'b1);
        alu_case(32'h8000_0000, 32'h0000_0001, 16'hFFFF, 1'b0);
        alu_case(32'h0000_0000, 32'h8000_0000, 16'h7FFF, 1'b0);
        alu_case(32'hFFFF_FFFE, 32'hFFFF_FFFF, 16'h0001, 1'b0);
        for (int it = 0; it < 20; it++) begin
            ra = $urandom;
            rb = $urandom;
            ri = 16'($urandom);
            alu_case(ra, rb, ri, 1'b0);
        end
        flow_case();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=%h expected=%h", imem_addr, 32'hFFFF_FFFF);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule